// File: doc/BRIEF.md
# Radix-Adjusted Borrow Execution Unit

This block runs one family of 13-bit instructions. Each takes a 4-bit nibble from data memory, removes the incoming carry flag from it and corrects the result to a radix given in the opcode. The radix can be 1 to 16, and a zero field means 16. The corrected nibble is written back to the same address. Chains of these instructions propagate a borrow through counters of any base, such as a decimal digit or a base-6 tens-of-seconds digit.

The unit holds the two 16-bit index registers and the C and Z flags. It also holds a one-shot address override. An extension load puts an 8-bit immediate into it, and the next non-incrementing instruction uses that immediate as its address. Memory is reached through a synchronous nibble port: one read cycle, then one write cycle. Write ports for the index registers and for C let the surrounding core place operands, and only accept writes while the unit is idle.

Top module: `radix_borrow_unit`

## Requirements
- R1: Only instruction words with bits [12:6] equal to 1110000 are executed. Bit 5 selects the index (0 = X, 1 = Y), bit 4 requests post-increment, and bits [3:0] give the radix, with 0 meaning 16. A start with any other word causes no memory access, leaves busy low and changes no state.
- R2: A start accepted while idle gives exactly one read cycle (memRdEn high) on the following cycle, then one write cycle (memWrEn high) to the same address. Busy is high for those two cycles. Flags and index registers change at the end of the write cycle.
- R3: If the read nibble is 0 and C is 1, the nibble written is radix−1 and C becomes 1. Otherwise the nibble written is the read nibble minus C, modulo 16, and C becomes 0. This rule also holds when the read nibble is already at or above the radix.
- R4: Z becomes 1 exactly when the nibble written back is 0.
- R5: With no pending override, the operand address is the selected index register.
- R6: In the post-increment form, the selected index register increases by 1 modulo 2^16 after the access. The other index register is unchanged, and the increment does not affect C or Z.
- R7: An extension load while idle and without start arms the override. The next non-incrementing instruction then uses address {8'h00, imm} for X or {8'hFF, imm} for Y.
- R8: Post-increment forms ignore an armed override and address through the index register.
- R9: The override is disarmed when any instruction completes, so it applies at most once.
- R10: Start, extension load, index writes and C writes presented while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction start strobe |
| instr | input | 13 | Instruction word |
| extLoad | input | 1 | Arm address override strobe |
| extImm | input | 8 | Override immediate |
| idxWr | input | 1 | Index register write strobe |
| idxWrSel | input | 1 | Index to write (0 = X, 1 = Y) |
| idxWrData | input | 16 | Index write value |
| cWr | input | 1 | Carry flag write strobe |
| cWrData | input | 1 | Carry flag write value |
| memAddr | output | 16 | Memory nibble address |
| memRdEn | output | 1 | Memory read strobe, data returned next cycle |
| memRdData | input | 4 | Read nibble |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 4 | Nibble to write |
| busy | output | 1 | Instruction in progress |
| flagC | output | 1 | Carry flag |
| flagZ | output | 1 | Zero flag |
| xIdx | output | 16 | X index register |
| yIdx | output | 16 | Y index register |

## Verification
The bench runs every combination of radix field, read nibble and carry against a reference model. This covers the radix-16 encoding, radix 1 and nibbles above the radix. A design that wrapped to the wrong value, or that read a zero field as 0 instead of 16, would write a wrong nibble. Further tests exercise the override against the post-increment forms and its one-shot clearing. A design that honoured the override on an incrementing form, or kept it armed, would put a wrong address on the memory port. Other tests cover the wrap of an index at FFFFh and inputs presented while busy. A design with those faults would corrupt the index registers or start a second access.

// File: rtl/rbu_pkg.sv
package rbu_pkg;
  localparam int OPC_W  = 13;
  localparam int NIB_W  = 4;
  localparam int ADDR_W = 16;
  localparam int IMM_W  = 8;
  localparam logic [6:0] OPC_PREFIX = 7'b1110000;

  typedef struct packed {
    logic idle;    // unit free to take side writes
    logic latch;   // capture instruction word
    logic rdEn;    // read cycle
    logic wrEn;    // write cycle
    logic commit;  // update flags, index, override at end of cycle
  } rbuStrobe_t;
endpackage

// File: rtl/rbu_ctrl.sv
module rbu_ctrl
  import rbu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [OPC_W-1:0] instr,
  output rbuStrobe_t       strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} state_t;
  state_t state;

  logic opcMatch;
  assign opcMatch = (instr[OPC_W-1 -: 7] == OPC_PREFIX);

  always_comb begin
    strobe.idle   = (state == ST_IDLE);
    strobe.latch  = (state == ST_IDLE) && start && opcMatch;
    strobe.rdEn   = (state == ST_READ);
    strobe.wrEn   = (state == ST_WRITE);
    strobe.commit = (state == ST_WRITE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else begin
      case (state)
        ST_IDLE:  if (strobe.latch) state <= ST_READ;
        ST_READ:  state <= ST_WRITE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  AST_WRITE_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |=> strobe.wrEn); // R2
  AST_READ_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.idle && start && opcMatch) |=> strobe.rdEn); // R2
  AST_BAD_OPCODE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.idle && !(start && opcMatch)) |=> strobe.idle); // R1
endmodule

// File: rtl/rbu_datapath.sv
module rbu_datapath
  import rbu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rbuStrobe_t        strobe,
  input  logic [OPC_W-1:0]  instr,
  input  logic              extLoad,
  input  logic [IMM_W-1:0]  extImm,
  input  logic              idxWr,
  input  logic              idxWrSel,
  input  logic [ADDR_W-1:0] idxWrData,
  input  logic              cWr,
  input  logic              cWrData,
  input  logic [NIB_W-1:0]  memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [NIB_W-1:0]  memWrData,
  output logic              flagC,
  output logic              flagZ,
  output logic [ADDR_W-1:0] xIdx,
  output logic [ADDR_W-1:0] yIdx
);
  localparam int RADIX_W = NIB_W + 1;

  logic [5:0]        opReg;
  logic              extValid;
  logic [IMM_W-1:0]  extReg;

  logic selY, postInc, useExt, borrow;
  logic [RADIX_W-1:0] radixVal;
  logic [NIB_W-1:0]   resNib;

  assign selY    = opReg[5];
  assign postInc = opReg[4];
  assign useExt  = extValid && !postInc;
  assign radixVal = (opReg[3:0] == '0) ? RADIX_W'(16) : {1'b0, opReg[3:0]};
  assign borrow  = flagC && (memRdData == '0);

  always_comb begin
    if (borrow) resNib = NIB_W'(radixVal - RADIX_W'(1));
    else        resNib = memRdData - NIB_W'(flagC);
  end

  always_comb begin
    if (useExt) memAddr = {{(ADDR_W-IMM_W){selY}}, extReg};
    else        memAddr = selY ? yIdx : xIdx;
  end
  assign memWrData = resNib;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg <= '0; extValid <= 1'b0; extReg <= '0;
      flagC <= 1'b0; flagZ <= 1'b0; xIdx <= '0; yIdx <= '0;
    end else begin
      if (strobe.latch) opReg <= instr[5:0];
      if (strobe.idle && !strobe.latch) begin
        if (extLoad) begin extValid <= 1'b1; extReg <= extImm; end
        if (idxWr) begin
          if (idxWrSel) yIdx <= idxWrData;
          else          xIdx <= idxWrData;
        end
        if (cWr) flagC <= cWrData;
      end
      if (strobe.commit) begin
        flagC    <= borrow;
        flagZ    <= (resNib == '0);
        extValid <= 1'b0;
        if (postInc) begin
          if (selY) yIdx <= yIdx + 1'b1;
          else      xIdx <= xIdx + 1'b1;
        end
      end
    end
  end

  AST_Z_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (flagZ == ($past(memWrData) == '0))); // R4
  AST_EXT_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> !extValid); // R9
  AST_INC_Y: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && postInc && selY) |=> (yIdx == $past(yIdx) + 1'b1) && $stable(xIdx)); // R6
  AST_INC_X: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && postInc && !selY) |=> (xIdx == $past(xIdx) + 1'b1) && $stable(yIdx)); // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |=> $stable(memAddr)); // R2
  AST_BUSY_NO_SIDE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn) |=> $stable(flagC) && $stable(xIdx) && $stable(yIdx)); // R10
endmodule

// File: rtl/radix_borrow_unit.sv
module radix_borrow_unit
  import rbu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OPC_W-1:0]  instr,
  input  logic              extLoad,
  input  logic [IMM_W-1:0]  extImm,
  input  logic              idxWr,
  input  logic              idxWrSel,
  input  logic [ADDR_W-1:0] idxWrData,
  input  logic              cWr,
  input  logic              cWrData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [NIB_W-1:0]  memRdData,
  output logic              memWrEn,
  output logic [NIB_W-1:0]  memWrData,
  output logic              busy,
  output logic              flagC,
  output logic              flagZ,
  output logic [ADDR_W-1:0] xIdx,
  output logic [ADDR_W-1:0] yIdx
);
  rbuStrobe_t strobe;

  rbu_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .instr(instr), .strobe(strobe)
  );

  rbu_datapath uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .instr(instr),
    .extLoad(extLoad), .extImm(extImm),
    .idxWr(idxWr), .idxWrSel(idxWrSel), .idxWrData(idxWrData),
    .cWr(cWr), .cWrData(cWrData), .memRdData(memRdData),
    .memAddr(memAddr), .memWrData(memWrData),
    .flagC(flagC), .flagZ(flagZ), .xIdx(xIdx), .yIdx(yIdx)
  );

  assign memRdEn = strobe.rdEn;
  assign memWrEn = strobe.wrEn;
  assign busy    = !strobe.idle;

  AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn)); // R2
endmodule

// File: tb/radix_borrow_unit_test.sv
module radix_borrow_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [12:0] instr = '0;
  logic        extLoad = 1'b0;
  logic [7:0]  extImm = '0;
  logic        idxWr = 1'b0;
  logic        idxWrSel = 1'b0;
  logic [15:0] idxWrData = '0;
  logic        cWr = 1'b0;
  logic        cWrData = 1'b0;
  logic [15:0] memAddr;
  logic        memRdEn;
  logic [3:0]  memRdData = '0;
  logic        memWrEn;
  logic [3:0]  memWrData;
  logic        busy, flagC, flagZ;
  logic [15:0] xIdx, yIdx;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [3:0]  memNib;
  logic [15:0] mX, mY, rdAddr;
  logic        mC, mZ, mExtV;
  logic [7:0]  mExt;

  always #2.5 clk = ~clk;

  radix_borrow_unit uut (.*);

  // memory model: synchronous read of a single programmable nibble
  always_ff @(posedge clk) if (memRdEn) memRdData <= memNib;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] refExec(input logic [3:0] field, input logic [3:0] nib, input logic c);
    int n;
    n = (field == 0) ? 16 : field;
    if (c && nib == 0) return {1'b1, 4'(n - 1)};
    return {1'b0, 4'(nib - c)};
  endfunction

  task automatic setIdx(input logic sel, input logic [15:0] v);
    @(negedge clk); idxWr = 1; idxWrSel = sel; idxWrData = v;
    @(negedge clk); idxWr = 0;
    if (sel) mY = v; else mX = v;
  endtask

  task automatic setC(input logic v);
    @(negedge clk); cWr = 1; cWrData = v;
    @(negedge clk); cWr = 0; mC = v;
  endtask

  task automatic armExt(input logic [7:0] v);
    @(negedge clk); extLoad = 1; extImm = v;
    @(negedge clk); extLoad = 0; mExtV = 1; mExt = v;
  endtask

  task automatic runInstr(input logic selY, input logic inc, input logic [3:0] field, input logic [3:0] nib);
    logic [15:0] expAddr;
    logic [4:0]  r;
    expAddr = (mExtV && !inc) ? {{8{selY}}, mExt} : (selY ? mY : mX);
    r = refExec(field, nib, mC);
    memNib = nib;
    @(negedge clk); start = 1; instr = {7'b1110000, selY, inc, field};
    @(negedge clk); start = 0;
    check(memRdEn && busy && !memWrEn, "R2 read cycle", {memRdEn, busy, memWrEn}, 3'b110);
    check(memAddr == expAddr, inc ? "R8 address" : (mExtV ? "R7 address" : "R5 address"), memAddr, expAddr);
    rdAddr = memAddr;
    @(negedge clk);
    check(memWrEn && !memRdEn && memAddr == rdAddr, "R2 write cycle", {memWrEn, memRdEn, memAddr}, {2'b10, rdAddr});
    check(memWrData == r[3:0], "R3 result", {field, nib, mC, memWrData}, {field, nib, mC, r[3:0]});
    @(negedge clk);
    mC = r[4]; mZ = (r[3:0] == 0); mExtV = 0;
    if (inc) begin if (selY) mY = mY + 1; else mX = mX + 1; end
    check(flagC == mC, "R3 carry", flagC, mC);
    check(flagZ == mZ, "R4 zero", flagZ, mZ);
    check(xIdx == mX && yIdx == mY, "R6 index", {xIdx, yIdx}, {mX, mY});
    check(!busy, "R2 idle after", busy, 0);
  endtask

  initial begin
    mX = 0; mY = 0; mC = 0; mZ = 0; mExtV = 0; mExt = 0; memNib = 0; rdAddr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(!busy && !memRdEn && !memWrEn && !flagC && !flagZ && xIdx == 0 && yIdx == 0,
          "R2 reset state", {busy, memRdEn, memWrEn, flagC, flagZ}, 0);

    // exhaustive radix x nibble x carry
    setIdx(0, 16'h0120);
    for (int f = 0; f < 16; f++)
      for (int nb = 0; nb < 16; nb++)
        for (int c = 0; c < 2; c++) begin
          setC(c[0]);
          runInstr(1'b0, 1'b0, f[3:0], nb[3:0]);
        end

    // R6 wrap of Y index, flags unaffected by increment
    setIdx(1, 16'hFFFF);
    setC(1);
    runInstr(1'b1, 1'b1, 4'd10, 4'd5);
    check(yIdx == 16'h0000, "R6 wrap", yIdx, 0);

    // R7 override on X and Y, then R9 one-shot
    armExt(8'h3C);
    runInstr(1'b0, 1'b0, 4'd6, 4'd2);
    runInstr(1'b0, 1'b0, 4'd6, 4'd2);
    check(memAddr == mX, "R9 override cleared", memAddr, mX);
    armExt(8'hA5);
    runInstr(1'b1, 1'b0, 4'd0, 4'd0);
    // R8 override ignored by increment form, and still cleared
    armExt(8'h77);
    runInstr(1'b1, 1'b1, 4'd3, 4'd1);
    runInstr(1'b1, 1'b0, 4'd3, 4'd1);

    // R1 non-matching opcode
    @(negedge clk); start = 1; instr = 13'h1C40;
    @(negedge clk); start = 0;
    check(!memRdEn && !busy, "R1 bad opcode ignored", {memRdEn, busy}, 0);
    @(negedge clk); start = 1; instr = 13'h0C05;
    @(negedge clk); start = 0;
    check(!memRdEn && !busy && xIdx == mX && flagC == mC, "R1 bad opcode no state", {memRdEn, busy}, 0);

    // R10 inputs while busy
    memNib = 4'd4;
    @(negedge clk); start = 1; instr = {7'b1110000, 1'b0, 1'b0, 4'd10};
    @(negedge clk); start = 1; instr = {7'b1110000, 1'b1, 1'b1, 4'd10};
    idxWr = 1; idxWrSel = 0; idxWrData = 16'hBEEF; cWr = 1; cWrData = ~mC; extLoad = 1; extImm = 8'h11;
    @(negedge clk); start = 0; idxWr = 0; cWr = 0; extLoad = 0;
    check(memWrEn && memAddr == mX, "R10 busy inputs ignored addr", memAddr, mX);
    @(negedge clk);
    begin
      logic [4:0] r;
      r = refExec(4'd10, 4'd4, mC);
      mC = r[4]; mZ = (r[3:0] == 0);
    end
    check(!busy && !memRdEn, "R10 no second start", {busy, memRdEn}, 0);
    check(xIdx == mX && yIdx == mY && flagC == mC, "R10 state kept", {xIdx, yIdx}, {mX, mY});
    runInstr(1'b0, 1'b0, 4'd10, 4'd7);

    // constrained random mix
    void'($urandom(32'h5EED));
    for (int i = 0; i < 300; i++) begin
      logic [31:0] rv;
      rv = $urandom();
      if (rv[20:18] == 0) setIdx(rv[21], rv[15:0]);
      if (rv[24:22] == 0) armExt(rv[31:24]);
      if (rv[25]) setC(rv[26]);
      runInstr(rv[27], rv[28], rv[3:0], rv[7:4]);
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule